// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter

This block keeps wall-clock time and a full calendar from a fast reference clock. A programmable prescaler, set with the wanted divide ratio minus one, turns the reference clock into a one-second step. The step advances seconds, minutes, hours, the weekday and the date. The date logic knows the length of every month and applies the Gregorian leap-year rule. A control input can force every year to be treated as a common year.

Software places a complete time and date on the setup inputs and pulses a load strobe. That copies all seven fields into the running counters at once and restarts the prescaler. A level enable starts and stops counting. A registered active flag reports whether counting is really taking place, and the running counters are always visible on read-only outputs.

Top module: `cal_rtc`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `active` is 0 and every `cur_*` output is 0.
- R2: `active` becomes 1 at the first clock edge after `enable` is seen high, and becomes 0 at the first clock edge after `enable` is seen low.
- R3: While `active` is 1, the seconds step fires once every `div_m1`+1 reference clocks. While `active` is 0, no counter changes unless a load occurs.
- R4: A clock edge with `load` high copies all seven `set_*` fields into the `cur_*` outputs, whether or not the block is active. If the seconds step falls on the same edge, the load wins and the step is discarded.
- R5: A load restarts the prescaler, so the first step after a load comes `div_m1`+1 clocks after the load edge.
- R6: On a step, seconds go from 59 to 0 and carry into minutes; minutes go from 59 to 0 and carry into hours; hours go from 23 to 0 and carry into the day.
- R7: Each day carry advances the weekday by one, wrapping from 6 to 0. In this encoding 0 is Sunday, 1 is Monday and 6 is Saturday.
- R8: On a day carry, the day of month goes back to 1 and the month advances after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. Otherwise the day of month increments. Both month and day count from 1.
- R9: February has 29 days in a leap year and 28 otherwise. A year is a leap year when it is divisible by 4 and not by 100, or when it is divisible by 400.
- R10: While `no_leap` is 1, February has 28 days in every year.
- R11: A day carry out of the last day of month 12 sets the month to 1 and increments the year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_m1 | input | 16 | Reference clocks per second, minus one |
| enable | input | 1 | Run request |
| load | input | 1 | Strobe that copies the setup fields into the counters |
| no_leap | input | 1 | Treat every year as a common year |
| set_year | input | 12 | Setup year |
| set_month | input | 4 | Setup month, 1 to 12 |
| set_day | input | 5 | Setup day of month, from 1 |
| set_dow | input | 3 | Setup weekday, 0 is Sunday |
| set_hour | input | 5 | Setup hour, 0 to 23 |
| set_min | input | 6 | Setup minute, 0 to 59 |
| set_sec | input | 6 | Setup second, 0 to 59 |
| active | output | 1 | Counting is running |
| cur_year | output | 12 | Running year |
| cur_month | output | 4 | Running month |
| cur_day | output | 5 | Running day of month |
| cur_dow | output | 3 | Running weekday |
| cur_hour | output | 5 | Running hour |
| cur_min | output | 6 | Running minute |
| cur_sec | output | 6 | Running second |

## Verification
A load strobe and a prescaler wrap can land on the same reference edge. The bench provokes this by loading, counting the clocks of one prescaler period, and then raising a second load with a new seconds value exactly on the wrap edge. The load counts as the winner if the seconds output shows the newly loaded value rather than that value plus one. The bench also confirms that the next step arrives a full period after the colliding edge and not earlier.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DOW_W  = 3;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;
  localparam int DOW_LAST  = 6;
  localparam int MON_LAST  = 12;

  // Gregorian rule with an override that removes every leap day
  function automatic logic is_leap(input int unsigned y, input logic force_common);
    logic by4, by100, by400;
    by4   = (y % 4)   == 0;
    by100 = (y % 100) == 0;
    by400 = (y % 400) == 0;
    return !force_common && ((by4 && !by100) || by400);
  endfunction

  function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] m,
                                                  input logic leap);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return DAY_W'(30);
      4'd2:                    return leap ? DAY_W'(29) : DAY_W'(28);
      default:                 return DAY_W'(31);
    endcase
  endfunction

endpackage

// File: rtl/rtc_run_ctl.sv
module rtc_run_ctl #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic active
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= enable;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], enable};
      end
    end
  endgenerate

  assign active = pipe[STAGES-1];

  assert_idle_after_reset_R1: assert property (@(posedge clk) rst |=> !active);

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div_m1);
  assign tick = run && !load && wrap;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (wrap)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // a load restarts the period, so no step directly follows it
  assert_restart_on_load_R5: assert property (@(posedge clk) disable iff (rst)
    (load && div_m1 != '0 && $stable(div_m1)) |=> !tick);

  assert_no_step_idle_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |=> !tick);

endmodule

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         carry
);
  logic at_end;

  assign at_end = (value >= W'(LAST));
  assign carry  = step && at_end;

  always_ff @(posedge clk) begin
    if (rst)        value <= '0;
    else if (load)  value <= load_val;
    else if (step)  value <= at_end ? '0 : value + 1'b1;
  end

  assert_wrap_range_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> value <= W'(LAST));

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import cal_rtc_pkg::*;
#(
  parameter int YEAR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [YEAR_W-1:0] set_year,
  input  logic [MON_W-1:0]  set_month,
  input  logic [DAY_W-1:0]  set_day,
  input  logic              day_step,
  input  logic              no_leap,
  output logic [YEAR_W-1:0] year,
  output logic [MON_W-1:0]  month,
  output logic [DAY_W-1:0]  day
);
  logic             leap;
  logic [DAY_W-1:0] last_day;
  logic             month_end;
  logic             year_end;

  assign leap      = is_leap(32'(year), no_leap);
  assign last_day  = month_days(month, leap);
  assign month_end = (day >= last_day);
  assign year_end  = (month >= MON_W'(MON_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      year  <= '0;
      month <= '0;
      day   <= '0;
    end else if (load) begin
      year  <= set_year;
      month <= set_month;
      day   <= set_day;
    end else if (day_step) begin
      if (month_end) begin
        day <= DAY_W'(1);
        if (year_end) begin
          month <= MON_W'(1);
          year  <= year + 1'b1;
        end else begin
          month <= month + 1'b1;
        end
      end else begin
        day <= day + 1'b1;
      end
    end
  end

  assert_day_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    (day_step && !load) |=> day != '0);

  assert_year_only_on_step_R11: assert property (@(posedge clk) disable iff (rst)
    (!day_step && !load) |=> $stable(year));

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int YEAR_W     = 12,
  parameter int RUN_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_m1,
  input  logic              enable,
  input  logic              load,
  input  logic              no_leap,
  input  logic [YEAR_W-1:0] set_year,
  input  logic [MON_W-1:0]  set_month,
  input  logic [DAY_W-1:0]  set_day,
  input  logic [DOW_W-1:0]  set_dow,
  input  logic [HOUR_W-1:0] set_hour,
  input  logic [MIN_W-1:0]  set_min,
  input  logic [SEC_W-1:0]  set_sec,
  output logic              active,
  output logic [YEAR_W-1:0] cur_year,
  output logic [MON_W-1:0]  cur_month,
  output logic [DAY_W-1:0]  cur_day,
  output logic [DOW_W-1:0]  cur_dow,
  output logic [HOUR_W-1:0] cur_hour,
  output logic [MIN_W-1:0]  cur_min,
  output logic [SEC_W-1:0]  cur_sec
);
  logic sec_step;
  logic min_step;
  logic hour_step;
  logic day_step;
  logic dow_carry;

  rtc_run_ctl #(.STAGES(RUN_STAGES)) u_run (
    .clk(clk), .rst(rst), .enable(enable), .active(active)
  );

  rtc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(active), .load(load),
    .div_m1(div_m1), .tick(sec_step)
  );

  rtc_wrap_cnt #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
    .clk(clk), .rst(rst), .load(load), .load_val(set_sec),
    .step(sec_step), .value(cur_sec), .carry(min_step)
  );

  rtc_wrap_cnt #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
    .clk(clk), .rst(rst), .load(load), .load_val(set_min),
    .step(min_step), .value(cur_min), .carry(hour_step)
  );

  rtc_wrap_cnt #(.W(HOUR_W), .LAST(HOUR_LAST)) u_hour (
    .clk(clk), .rst(rst), .load(load), .load_val(set_hour),
    .step(hour_step), .value(cur_hour), .carry(day_step)
  );

  rtc_wrap_cnt #(.W(DOW_W), .LAST(DOW_LAST)) u_dow (
    .clk(clk), .rst(rst), .load(load), .load_val(set_dow),
    .step(day_step), .value(cur_dow), .carry(dow_carry)
  );

  rtc_date_chain #(.YEAR_W(YEAR_W)) u_date (
    .clk(clk), .rst(rst), .load(load),
    .set_year(set_year), .set_month(set_month), .set_day(set_day),
    .day_step(day_step), .no_leap(no_leap),
    .year(cur_year), .month(cur_month), .day(cur_day)
  );

  assert_load_copies_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_sec == $past(set_sec) && cur_min == $past(set_min) &&
              cur_hour == $past(set_hour) && cur_dow == $past(set_dow) &&
              cur_day == $past(set_day) && cur_year == $past(set_year)));

  assert_frozen_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!active && !load) |=> ($stable(cur_sec) && $stable(cur_day)));

  assert_active_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (RUN_STAGES == 1 && enable) |=> active);

  assert_dow_range_R7: assert property (@(posedge clk) disable iff (rst)
    (day_step && !dow_carry) |=> cur_dow != '0);

endmodule

// File: tb/test_cal_rtc.sv
`timescale 1ns/1ps
module test_cal_rtc;

  typedef struct packed {
    logic [11:0] y;
    logic [3:0]  mo;
    logic [4:0]  d;
    logic [2:0]  w;
    logic [4:0]  h;
    logic [5:0]  mi;
    logic [5:0]  s;
  } cal_t;

  typedef struct packed {
    cal_t       start;
    logic       nl;
    cal_t       after;
    logic [3:0] req;
  } vec_t;

  // each vector: loaded value, force flag, value after one step, requirement
  localparam vec_t VECS [16] = '{
    '{'{12'd2023, 4'd3,  5'd14, 3'd2, 5'd10, 6'd20, 6'd30}, 1'b0, '{12'd2023, 4'd3,  5'd14, 3'd2, 5'd10, 6'd20, 6'd31}, 4'd3},  // R3
    '{'{12'd2023, 4'd3,  5'd14, 3'd2, 5'd10, 6'd20, 6'd59}, 1'b0, '{12'd2023, 4'd3,  5'd14, 3'd2, 5'd10, 6'd21, 6'd0},  4'd6},  // R6
    '{'{12'd2023, 4'd3,  5'd14, 3'd2, 5'd10, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd3,  5'd14, 3'd2, 5'd11, 6'd0,  6'd0},  4'd6},  // R6
    '{'{12'd2023, 4'd3,  5'd14, 3'd2, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd3,  5'd15, 3'd3, 5'd0,  6'd0,  6'd0},  4'd7},  // R7
    '{'{12'd2023, 4'd3,  5'd18, 3'd6, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd3,  5'd19, 3'd0, 5'd0,  6'd0,  6'd0},  4'd7},  // R7
    '{'{12'd2023, 4'd4,  5'd30, 3'd0, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd5,  5'd1,  3'd1, 5'd0,  6'd0,  6'd0},  4'd8},  // R8
    '{'{12'd2023, 4'd1,  5'd31, 3'd2, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd2,  5'd1,  3'd3, 5'd0,  6'd0,  6'd0},  4'd8},  // R8
    '{'{12'd2023, 4'd4,  5'd29, 3'd6, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd4,  5'd30, 3'd0, 5'd0,  6'd0,  6'd0},  4'd8},  // R8
    '{'{12'd2023, 4'd2,  5'd28, 3'd2, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd3,  5'd1,  3'd3, 5'd0,  6'd0,  6'd0},  4'd9},  // R9
    '{'{12'd2024, 4'd2,  5'd28, 3'd3, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2024, 4'd2,  5'd29, 3'd4, 5'd0,  6'd0,  6'd0},  4'd9},  // R9
    '{'{12'd2024, 4'd2,  5'd29, 3'd4, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2024, 4'd3,  5'd1,  3'd5, 5'd0,  6'd0,  6'd0},  4'd9},  // R9
    '{'{12'd1900, 4'd2,  5'd28, 3'd3, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd1900, 4'd3,  5'd1,  3'd4, 5'd0,  6'd0,  6'd0},  4'd9},  // R9
    '{'{12'd2000, 4'd2,  5'd28, 3'd1, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2000, 4'd2,  5'd29, 3'd2, 5'd0,  6'd0,  6'd0},  4'd9},  // R9
    '{'{12'd2024, 4'd2,  5'd28, 3'd3, 5'd23, 6'd59, 6'd59}, 1'b1, '{12'd2024, 4'd3,  5'd1,  3'd4, 5'd0,  6'd0,  6'd0},  4'd10}, // R10
    '{'{12'd2023, 4'd12, 5'd31, 3'd0, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2024, 4'd1,  5'd1,  3'd1, 5'd0,  6'd0,  6'd0},  4'd11}, // R11
    '{'{12'd2023, 4'd11, 5'd30, 3'd4, 5'd23, 6'd59, 6'd59}, 1'b0, '{12'd2023, 4'd12, 5'd1,  3'd5, 5'd0,  6'd0,  6'd0},  4'd8}   // R8
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] div_m1;
  logic        enable, load, no_leap;
  logic [11:0] set_year;
  logic [3:0]  set_month;
  logic [4:0]  set_day;
  logic [2:0]  set_dow;
  logic [4:0]  set_hour;
  logic [5:0]  set_min, set_sec;
  logic        active;
  logic [11:0] cur_year;
  logic [3:0]  cur_month;
  logic [4:0]  cur_day;
  logic [2:0]  cur_dow;
  logic [4:0]  cur_hour;
  logic [5:0]  cur_min, cur_sec;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cal_rtc i_cal_rtc (
    .clk(clk), .rst(rst), .div_m1(div_m1), .enable(enable), .load(load),
    .no_leap(no_leap), .set_year(set_year), .set_month(set_month),
    .set_day(set_day), .set_dow(set_dow), .set_hour(set_hour),
    .set_min(set_min), .set_sec(set_sec), .active(active),
    .cur_year(cur_year), .cur_month(cur_month), .cur_day(cur_day),
    .cur_dow(cur_dow), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_cal(input string req, input cal_t e);
    check(req, "year",  cur_year,  e.y);
    check(req, "month", cur_month, e.mo);
    check(req, "day",   cur_day,   e.d);
    check(req, "dow",   cur_dow,   e.w);
    check(req, "hour",  cur_hour,  e.h);
    check(req, "min",   cur_min,   e.mi);
    check(req, "sec",   cur_sec,   e.s);
  endtask

  task automatic apply(input cal_t c, input logic nl);
    set_year = c.y; set_month = c.mo; set_day = c.d; set_dow = c.w;
    set_hour = c.h; set_min = c.mi; set_sec = c.s; no_leap = nl;
    load = 1'b1;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cal_t c;
    logic [5:0] held;
    rst = 1'b1; enable = 1'b0; load = 1'b0; no_leap = 1'b0; div_m1 = 16'd3;
    apply('0, 1'b0); load = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "active in reset", active, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "active", active, 0);
    check_cal("R1", '0);

    // R2 rise
    enable = 1'b1;
    @(negedge clk);
    check("R2", "active rise", active, 1);

    // vector table: load, hold one period, step once
    for (int i = 0; i < 16; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      apply(VECS[i].start, VECS[i].nl);
      @(negedge clk);
      load = 1'b0;
      check_cal("R4", VECS[i].start);
      repeat (3) @(negedge clk);
      check("R5", "sec before step", cur_sec, VECS[i].start.s);
      @(negedge clk);
      check_cal(rq, VECS[i].after);
    end
    no_leap = 1'b0;

    // R4 collision: a load on the wrap edge wins over the step
    c = '{12'd2023, 4'd6, 5'd10, 3'd6, 5'd12, 6'd0, 6'd0};
    apply(c, 1'b0);
    @(negedge clk);
    load = 1'b0;
    repeat (3) @(negedge clk);
    c.s = 6'd40;
    apply(c, 1'b0);
    @(negedge clk);
    load = 1'b0;
    check("R4", "collision sec", cur_sec, 40);
    check("R4", "collision min", cur_min, 0);
    repeat (3) @(negedge clk);
    check("R5", "no early step", cur_sec, 40);
    @(negedge clk);
    check("R5", "step after period", cur_sec, 41);

    // R3 longer period: div_m1 = 9
    c.s = 6'd0;
    div_m1 = 16'd9;
    apply(c, 1'b0);
    @(negedge clk);
    load = 1'b0;
    repeat (29) @(negedge clk);
    check("R3", "two steps", cur_sec, 2);
    @(negedge clk);
    check("R3", "three steps", cur_sec, 3);

    // R2 fall, then counters frozen
    enable = 1'b0;
    @(negedge clk);
    check("R2", "active fall", active, 0);
    held = cur_sec;
    repeat (40) @(negedge clk);
    check("R3", "frozen while idle", cur_sec, held);

    // R4 load while stopped
    c = '{12'd2030, 4'd7, 5'd4, 3'd4, 5'd8, 6'd15, 6'd20};
    apply(c, 1'b0);
    @(negedge clk);
    load = 1'b0;
    check_cal("R4", c);
    check("R4", "still idle", active, 0);

    // R2 restart; first step one full period after active rises
    enable = 1'b1;
    @(negedge clk);
    check("R2", "active again", active, 1);
    repeat (9) @(negedge clk);
    check("R3", "no step yet", cur_sec, 20);
    @(negedge clk);
    check("R3", "step after restart", cur_sec, 21);

    finish_run();
  end

endmodule